// File: doc/BRIEF.md
# Data-Space Router with Per-Region Wait States

This block sits between a small CPU core and its on-chip storage. It splits a flat 16-bit byte address space into three targets: a bank of I/O registers at the bottom, a 1 KB window onto the EEPROM page buffer, and internal SRAM. The CPU presents one access at a time and holds address, data and strobes steady. The router answers with `cpu_ready` after a wait that depends on the target and on whether the access reads or writes.

Sequential EEPROM reads are pipelined. After the first one, each read to the next byte completes one cycle sooner than a fresh read. The lowest I/O registers also accept single-bit set, clear and test operations. An address that falls in the unmapped gap, or above the end of the configured SRAM, raises an error flag on its single completion cycle. Behavioural models of the three storage arrays are part of the block.

Top module: `dspace_router`

## Requirements
- R1: In reset and right after it, `cpu_ready` and `cpu_err` are low and `cpu_rdata` is zero. Every implemented I/O register reads as zero until it is written.
- R2: Reads and writes to 0x0000–0x0FFF (I/O) complete with `cpu_ready` high in the first cycle the strobe is seen.
- R3: SRAM starts at 0x2000 and ends at 0x27FF, or at 0x2FFF when `BIG_SRAM` is 1. An SRAM write completes in its first cycle and an SRAM read completes in its second cycle.
- R4: Addresses 0x1000–0x13FF reach the EEPROM page buffer. A write completes in its first cycle. A read that does not qualify under R5 completes in its third cycle.
- R5: An EEPROM read to the buffer offset exactly one above the last completed EEPROM read completes in its second cycle. This holds only if no other access has completed in between. Idle cycles do not break the run.
- R6: Any other access completing between two EEPROM reads, or a non-consecutive offset, brings back the three-cycle read. Offset 0x3FF followed by offset 0x000 counts as non-consecutive.
- R7: An access to 0x1400–0x1FFF or above the SRAM end completes in its first cycle with `cpu_err` high and `cpu_rdata` zero. If it is a write, it changes no storage.
- R8: A nonzero `cpu_bop` makes the access a bit operation on register `cpu_addr`, bit `cpu_bit`, and `cpu_rd`/`cpu_wr` are then ignored. The codes are 01 set, 10 clear and 11 test. The access completes in its first cycle. Set and clear change only the selected bit. Test returns the bit in `cpu_rdata[0]` with the other bits zero.
- R9: A bit operation at an address of 0x0020 or above is rejected. It completes in its first cycle with `cpu_err` high and changes no storage.
- R10: While `cpu_ready` is low, `cpu_rdata` is zero and `cpu_err` is low. On a completing write, set or clear, `cpu_rdata` is zero.
- R11: I/O addresses at or above `IO_DEPTH` (default 64) and below 0x1000 read as zero without error. Writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Byte address of the access |
| cpu_wdata | input | 8 | Write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_bop | input | 2 | Bit-operation code (00 none, 01 set, 10 clear, 11 test) |
| cpu_bit | input | 3 | Bit index for bit operations |
| cpu_rdata | output | 8 | Read data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_err | output | 1 | Completed access was rejected |

## Verification
The hardest state to reach is the shortened EEPROM read. It only appears after an earlier EEPROM read has completed, and it must vanish the moment any other access completes. The stimulus builds chains of consecutive EEPROM reads. It breaks those chains in each possible way: a jump in offset, an I/O write, an SRAM read, and the wrap from the last buffer byte. It also inserts idle cycles, which must not break a chain. The fault path gets the same treatment: writes aimed at the gap and past the SRAM end are followed by reads of the locations they would alias onto if decoding were wrong.

// File: rtl/dspace_pkg.sv
package dspace_pkg;
    localparam int EE_BYTES = 1024;
    localparam int EE_W     = $clog2(EE_BYTES);

    localparam logic [15:0] IO_TOP     = 16'h1000;
    localparam logic [15:0] EE_BASE    = 16'h1000;
    localparam logic [15:0] EE_LAST    = 16'h13FF;
    localparam logic [15:0] SRAM_BASE  = 16'h2000;
    localparam logic [15:0] BITOP_TOP  = 16'h0020;

    typedef enum logic [1:0] {RG_IO, RG_EE, RG_SRAM, RG_NONE} region_t;

    typedef enum logic [2:0] {OP_NONE, OP_READ, OP_WRITE, OP_BSET, OP_BCLR, OP_BTST} op_t;

    typedef struct packed {
        logic [1:0]      cnt;
        logic            run_v;
        logic [EE_W-1:0] run_off;
    } seq_t;
endpackage

// File: rtl/dspace_decode.sv
module dspace_decode
    import dspace_pkg::*;
#(
    parameter int SRAM_BYTES = 2048
) (
    input  logic [15:0] addr,
    input  logic        rd,
    input  logic        wr,
    input  logic [1:0]  bop,
    output op_t         op,
    output region_t     region,
    output logic        fault
);
    localparam logic [16:0] SRAM_LIMIT = 17'(32'(SRAM_BASE) + SRAM_BYTES);

    logic is_bit;

    always_comb begin
        if (addr < IO_TOP)
            region = RG_IO;
        else if (addr >= EE_BASE && addr <= EE_LAST)
            region = RG_EE;
        else if (addr >= SRAM_BASE && {1'b0, addr} < SRAM_LIMIT)
            region = RG_SRAM;
        else
            region = RG_NONE;

        unique case (bop)
            2'b01:   op = OP_BSET;
            2'b10:   op = OP_BCLR;
            2'b11:   op = OP_BTST;
            default: op = wr ? OP_WRITE : (rd ? OP_READ : OP_NONE);
        endcase

        is_bit = (bop != 2'b00);
        fault  = (op != OP_NONE) &&
                 ((region == RG_NONE) || (is_bit && addr >= BITOP_TOP));
    end
endmodule

// File: rtl/dspace_store.sv
module dspace_store #(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/dspace_iobank.sv
module dspace_iobank #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          bset,
    input  logic          bclr,
    input  logic [AW-1:0] addr,
    input  logic [2:0]    bsel,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] reg_q [DEPTH];
    logic [7:0] reg_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) reg_d[i] = reg_q[i];
        if (we)   reg_d[addr] = wdata;
        if (bset) reg_d[addr][bsel] = 1'b1;
        if (bclr) reg_d[addr][bsel] = 1'b0;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) reg_q[i] <= 8'h00;
            else        reg_q[i] <= reg_d[i];
        end
    end

    assign rdata = reg_q[addr];
endmodule

// File: rtl/dspace_router.sv
module dspace_router
    import dspace_pkg::*;
#(
    parameter bit BIG_SRAM = 1'b0,
    parameter int IO_DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    input  logic [1:0]  cpu_bop,
    input  logic [2:0]  cpu_bit,
    output logic [7:0]  cpu_rdata,
    output logic        cpu_ready,
    output logic        cpu_err
);
    localparam int SRAM_BYTES = BIG_SRAM ? 4096 : 2048;
    localparam int SR_W       = $clog2(SRAM_BYTES);
    localparam int IO_W       = $clog2(IO_DEPTH);

    op_t     op;
    region_t region;
    logic    fault;

    dspace_decode #(.SRAM_BYTES(SRAM_BYTES)) u_dec (
        .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr), .bop(cpu_bop),
        .op(op), .region(region), .fault(fault)
    );

    seq_t s_q, s_d;

    logic       active, ready, io_hit, ee_next, ee_rd;
    logic [1:0] lat;
    logic       go;
    logic       io_we, io_set, io_clr, ee_we, sr_we;
    logic [7:0] io_rdata, ee_rdata, sr_rdata, rdata_c;

    always_comb begin
        active  = (op != OP_NONE);
        io_hit  = (cpu_addr[11:IO_W] == '0);
        ee_next = s_q.run_v &&
                  ({1'b0, cpu_addr[EE_W-1:0]} == ({1'b0, s_q.run_off} + 11'd1));

        if (fault)                               lat = 2'd1;
        else if (region == RG_SRAM && op == OP_READ) lat = 2'd2;
        else if (region == RG_EE && op == OP_READ)   lat = ee_next ? 2'd2 : 2'd3;
        else                                     lat = 2'd1;

        ready = active && (s_q.cnt == lat - 2'd1);
        go    = ready && !fault;
        ee_rd = go && op == OP_READ && region == RG_EE;

        io_we  = go && op == OP_WRITE && region == RG_IO && io_hit;
        io_set = go && op == OP_BSET;
        io_clr = go && op == OP_BCLR;
        ee_we  = go && op == OP_WRITE && region == RG_EE;
        sr_we  = go && op == OP_WRITE && region == RG_SRAM;

        rdata_c = 8'h00;
        if (go && op == OP_READ) begin
            unique case (region)
                RG_IO:   rdata_c = io_hit ? io_rdata : 8'h00;
                RG_EE:   rdata_c = ee_rdata;
                RG_SRAM: rdata_c = sr_rdata;
                default: rdata_c = 8'h00;
            endcase
        end else if (go && op == OP_BTST) begin
            rdata_c = {7'b0, io_rdata[cpu_bit]};
        end

        s_d = s_q;
        if (ready) begin
            s_d.cnt   = 2'd0;
            s_d.run_v = ee_rd;
            if (ee_rd) s_d.run_off = cpu_addr[EE_W-1:0];
        end else if (active) begin
            s_d.cnt = s_q.cnt + 2'd1;
        end else begin
            s_d.cnt = 2'd0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    dspace_iobank #(.DEPTH(IO_DEPTH)) u_io (
        .clk(clk), .rst_n(rst_n), .we(io_we), .bset(io_set), .bclr(io_clr),
        .addr(cpu_addr[IO_W-1:0]), .bsel(cpu_bit), .wdata(cpu_wdata),
        .rdata(io_rdata)
    );

    dspace_store #(.DEPTH(EE_BYTES)) u_ee (
        .clk(clk), .we(ee_we), .addr(cpu_addr[EE_W-1:0]),
        .wdata(cpu_wdata), .rdata(ee_rdata)
    );

    dspace_store #(.DEPTH(SRAM_BYTES)) u_sram (
        .clk(clk), .we(sr_we), .addr(cpu_addr[SR_W-1:0]),
        .wdata(cpu_wdata), .rdata(sr_rdata)
    );

    assign cpu_rdata = rdata_c;
    assign cpu_ready = ready;
    assign cpu_err   = ready && fault;

    // R10
    quiet_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |-> (cpu_rdata == 8'h00 && !cpu_err));

    // R7
    err_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err |-> (cpu_ready && cpu_rdata == 8'h00));

    // R2
    io_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_rd || cpu_wr) && cpu_bop == 2'b00 && cpu_addr < 16'h1000) |-> cpu_ready);

    // R3
    sram_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_rd && !cpu_wr && cpu_bop == 2'b00 &&
         cpu_addr >= 16'h2000 && cpu_addr < 16'h2800)
        |-> ($past(cpu_rd) && !$past(cpu_ready)));

    // R4
    ee_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_rd && !cpu_wr && cpu_bop == 2'b00 &&
         cpu_addr >= 16'h1000 && cpu_addr < 16'h1400)
        |-> ($past(cpu_rd) && !$past(cpu_ready)));

    // R9
    bitop_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_bop != 2'b00 && cpu_addr >= 16'h0020) |-> cpu_err);
endmodule

// File: tb/dspace_router_test.sv
module dspace_router_test;
    localparam int K_RD = 0, K_WR = 1, K_SET = 2, K_CLR = 3, K_TST = 4;
    localparam int SR_END = 16'h3000;
    localparam int IOD = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [1:0]  cpu_bop = '0;
    logic [2:0]  cpu_bit = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_ready, cpu_err;

    int n_chk = 0, n_err = 0;

    int io_m [IOD];
    int ee_m [1024];
    int sr_m [4096];
    bit run_v = 1'b0;
    int run_off = 0;

    always #5 clk = ~clk;

    dspace_router #(.BIG_SRAM(1'b1), .IO_DEPTH(IOD)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_bop(cpu_bop), .cpu_bit(cpu_bit),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .cpu_err(cpu_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h (ready,err,rdata)", tag, act, exp);
        end
    endtask

    function automatic int obs();
        return {22'b0, cpu_ready, cpu_err, cpu_rdata};
    endfunction

    function automatic int pack(input bit r, input bit e, input int d);
        return (int'(r) << 9) | (int'(e) << 8) | (d & 8'hFF);
    endfunction

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_bop = 2'b00;
            #1 chk(tag, obs(), pack(0, 0, 0));
        end
    endtask

    task automatic acc(input int kind, input int a, input int d, input int b, input string tag);
        int rg, lat, bop, exp_d;
        bit flt;
        bop = (kind == K_SET) ? 1 : (kind == K_CLR) ? 2 : (kind == K_TST) ? 3 : 0;
        if (a < 16'h1000)                      rg = 0;
        else if (a < 16'h1400)                 rg = 1;
        else if (a >= 16'h2000 && a < SR_END)  rg = 2;
        else                                   rg = 3;
        flt = (rg == 3) || (bop != 0 && a >= 32);
        if (flt)                          lat = 1;
        else if (rg == 2 && kind == K_RD) lat = 2;
        else if (rg == 1 && kind == K_RD) lat = (run_v && (a - 16'h1000) == run_off + 1) ? 2 : 3;
        else                              lat = 1;
        exp_d = 0;
        if (!flt && kind == K_RD) begin
            if (rg == 0)      exp_d = (a < IOD) ? io_m[a] : 0;
            else if (rg == 1) exp_d = ee_m[a - 16'h1000];
            else              exp_d = sr_m[a - 16'h2000];
        end else if (!flt && kind == K_TST) begin
            exp_d = (io_m[a] >> b) & 1;
        end

        @(negedge clk);
        cpu_addr  = 16'(a);
        cpu_wdata = 8'(d);
        cpu_rd    = (kind == K_RD);
        cpu_wr    = (kind == K_WR);
        cpu_bop   = 2'(bop);
        cpu_bit   = 3'(b);
        for (int c = 1; c <= lat; c++) begin
            #1;
            if (c < lat) chk(tag, obs(), pack(0, 0, 0));
            else         chk(tag, obs(), pack(1, flt, exp_d));
            if (c < lat) @(negedge clk);
        end

        if (!flt) begin
            if (kind == K_WR) begin
                if (rg == 0 && a < IOD) io_m[a] = d & 8'hFF;
                else if (rg == 1)       ee_m[a - 16'h1000] = d & 8'hFF;
                else if (rg == 2)       sr_m[a - 16'h2000] = d & 8'hFF;
            end else if (kind == K_SET) begin
                io_m[a] = io_m[a] | (1 << b);
            end else if (kind == K_CLR) begin
                io_m[a] = io_m[a] & ~(1 << b) & 8'hFF;
            end
        end
        if (!flt && kind == K_RD && rg == 1) begin
            run_v = 1'b1; run_off = a - 16'h1000;
        end else begin
            run_v = 1'b0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < IOD; i++) io_m[i] = 0;
        repeat (3) @(negedge clk);
        #1 chk("R1 in reset", obs(), pack(0, 0, 0));
        @(negedge clk) rst_n = 1'b1;
        #1 chk("R1 after reset", obs(), pack(0, 0, 0));
        acc(K_RD, 16'h0003, 0, 0, "R1 io reg zero");
        acc(K_RD, 16'h001F, 0, 0, "R1 io reg zero");

        acc(K_WR, 16'h0005, 8'hA5, 0, "R2 io write");
        acc(K_RD, 16'h0005, 0, 0, "R2 io read");
        acc(K_WR, 16'h003F, 8'h3C, 0, "R2 io write top reg");
        acc(K_RD, 16'h003F, 0, 0, "R2 io read top reg");

        acc(K_WR, 16'h0040, 8'h77, 0, "R11 unimplemented io write");
        acc(K_RD, 16'h0040, 0, 0, "R11 unimplemented io read");
        acc(K_RD, 16'h0000, 0, 0, "R11 no alias onto reg 0");
        acc(K_RD, 16'h0FFF, 0, 0, "R11 io top address");

        acc(K_WR, 16'h2000, 8'h11, 0, "R3 sram write");
        acc(K_WR, 16'h2FFF, 8'h22, 0, "R3 sram write end");
        acc(K_WR, 16'h2800, 8'h33, 0, "R3 sram write big part");
        acc(K_RD, 16'h2000, 0, 0, "R3 sram read");
        acc(K_RD, 16'h2FFF, 0, 0, "R3 sram read end");
        acc(K_RD, 16'h2800, 0, 0, "R3 sram read big part");

        for (int i = 0; i < 8; i++)
            acc(K_WR, 16'h1000 + i, 8'h40 + i, 0, "R4 ee write");
        acc(K_WR, 16'h13FE, 8'hE1, 0, "R4 ee write");
        acc(K_WR, 16'h13FF, 8'hE2, 0, "R4 ee write last");
        acc(K_RD, 16'h1003, 0, 0, "R4 ee read");
        acc(K_RD, 16'h1004, 0, 0, "R5 burst read");
        acc(K_RD, 16'h1005, 0, 0, "R5 burst read");
        idle(2, "R10 idle");
        acc(K_RD, 16'h1006, 0, 0, "R5 burst after idle");
        acc(K_RD, 16'h1000, 0, 0, "R6 jump back");
        acc(K_WR, 16'h0006, 8'h5A, 0, "R2 io write");
        acc(K_RD, 16'h1001, 0, 0, "R6 broken by write");
        acc(K_RD, 16'h1002, 0, 0, "R5 burst read");
        acc(K_RD, 16'h2000, 0, 0, "R3 sram read");
        acc(K_RD, 16'h1003, 0, 0, "R6 broken by sram read");
        acc(K_RD, 16'h13FE, 0, 0, "R6 jump");
        acc(K_RD, 16'h13FF, 0, 0, "R5 burst to last");
        acc(K_RD, 16'h1000, 0, 0, "R6 no wrap");

        acc(K_RD, 16'h1400, 0, 0, "R7 gap start");
        acc(K_RD, 16'h1FFF, 0, 0, "R7 gap end");
        acc(K_RD, 16'h3000, 0, 0, "R7 past sram");
        acc(K_RD, 16'hFFFF, 0, 0, "R7 top");
        acc(K_WR, 16'h1400, 8'hBB, 0, "R7 gap write");
        acc(K_RD, 16'h1000, 0, 0, "R7 ee untouched");
        acc(K_WR, 16'h3000, 8'hCC, 0, "R7 write past sram");
        acc(K_RD, 16'h2000, 0, 0, "R7 sram untouched");

        acc(K_SET, 16'h0005, 0, 1, "R8 set");
        acc(K_RD, 16'h0005, 0, 0, "R8 after set");
        acc(K_CLR, 16'h0005, 0, 7, "R8 clear");
        acc(K_RD, 16'h0005, 0, 0, "R8 after clear");
        acc(K_TST, 16'h0005, 0, 0, "R8 test one");
        acc(K_TST, 16'h0005, 0, 3, "R8 test zero");
        acc(K_SET, 16'h001F, 0, 4, "R8 set top of range");
        acc(K_RD, 16'h001F, 0, 0, "R8 after set top");

        acc(K_WR, 16'h0020, 8'h55, 0, "R2 io write");
        acc(K_SET, 16'h0020, 0, 1, "R9 set out of range");
        acc(K_CLR, 16'h0020, 0, 0, "R9 clear out of range");
        acc(K_RD, 16'h0020, 0, 0, "R9 reg unchanged");
        acc(K_TST, 16'h1000, 0, 0, "R9 test in ee window");
        idle(2, "R10 final idle");

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule